// File: doc/BRIEF.md
# Thread context CAM matcher

This block sits beside a hardware thread's context register file. For each incoming notification it decides which privilege ring of that thread, if any, is the target. The four context words (physical, pool, OS and user ring) reach the block in big-endian byte order. The block byte-swaps them and pulls out a valid bit and a CAM or logical-server field from each. It then compares those fields against the target, which is formed from a block and an index.

The physical ring has no stored CAM. Its line is built from the chip block id and the processor thread id, plus a marker bit whose position depends on the configured thread-id width.

In format 0 the rings are tried in a fixed priority order. A format-0 request that asks for low identifier bits to be ignored is reported as unsupported and never matches. In format 1 only the user-level path applies.

An optional output register, chosen by a parameter, lets the block sit on a timing-critical path.

Top module: `ctx_cam_match`

## Requirements
- R1: The target CAM value is {target block, target index}, CAM_W = BLK_W + IDX_W bits wide. A ring's CAM field is bits [CAM_W-1:0] of its word after byte swapping. Every bit, block included, must be equal for a match.
- R2: Each context word input carries bits 31:24 of the word on lane [7:0], bits 23:16 on [15:8], bits 15:8 on [23:16] and bits 7:0 on [31:24]. Fields are taken only after undoing this order.
- R3: The physical-ring line is {chip block, IDX_W-bit index}. In 7-bit mode (tid8_mode_i = 0) the index is thread_id[6:0] with a 1 at bit 7. In 8-bit mode the index is thread_id[7:0] with a 1 at bit 8. All higher index bits are 0.
- R4: With format 0 and the ignore bit set, unsupp_o is 1 and hit_o is 0, whatever the context words hold.
- R5: With format 0 and the ignore bit clear, the rings are tried in the order physical, pool, OS. The first that matches is reported. Ring codes are physical = 3, pool = 2 and OS = 1.
- R6: A ring needs its valid bit (bit 31 after swapping) set to match. The physical ring needs its valid bit and its synthesized line equal to the target. The pool and OS rings need their valid bit and their own CAM field equal to the target.
- R7: With format 1 only the user ring (code 0) can match, and the ignore bit has no effect. The match needs all of the following: the OS word valid with its CAM equal to the target, the user word valid, and bits [LS_W-1:0] of the user word equal to lsrv_i.
- R8: When no match is made, hit_o, ring_o and unsupp_o are all 0. unsupp_o is 1 only in the R4 case.
- R9: With REG_OUT = 1 the outputs appear one clock after the inputs, and reset (rst_n low) holds all outputs at 0. With REG_OUT = 0 the outputs follow the inputs without a clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt_i | input | 1 | Notification format: 0 ring match, 1 user-level |
| ignore_i | input | 1 | Ignore low identifier bits request |
| tgt_blk_i | input | BLK_W | Target block |
| tgt_idx_i | input | IDX_W | Target index |
| lsrv_i | input | LS_W | Requested logical-server number |
| phys_word_i | input | 32 | Physical ring context word, big-endian bytes |
| pool_word_i | input | 32 | Pool ring context word, big-endian bytes |
| os_word_i | input | 32 | OS ring context word, big-endian bytes |
| user_word_i | input | 32 | User ring context word, big-endian bytes |
| chip_blk_i | input | BLK_W | Block id of this chip |
| thread_id_i | input | TID_W | Processor thread id |
| tid8_mode_i | input | 1 | 1 selects the 8-bit thread id line |
| hit_o | output | 1 | A ring matched |
| ring_o | output | 2 | Matching ring code, 0 when no match |
| unsupp_o | output | 1 | Request form not supported |

## Verification
The bench instantiates the block twice with the default widths (4-bit block, 19-bit index, 8-bit thread id, 8-bit logical server). One instance has REG_OUT = 1 and the other REG_OUT = 0, so the same stimulus checks both the registered one-cycle timing and the combinational path.

With a 19-bit index, both marker positions of the physical line fit in the index. A thread id whose bit 7 is set therefore gives different lines in 7-bit and 8-bit mode. Random vectors are biased so that CAM fields often equal the target and the chip block often lines up with it. This makes priority contests between two or three matching rings frequent rather than rare.

// File: rtl/tcm_pkg.sv
package tcm_pkg;

  localparam int WORD_W  = 32;
  localparam int NBYTES  = WORD_W / 8;
  localparam int VLD_BIT = WORD_W - 1;
  localparam int NRINGS  = 4;

  // ring codes double as the index of the ring in the context word array
  typedef enum logic [1:0] {
    RING_USER = 2'd0,
    RING_OS   = 2'd1,
    RING_POOL = 2'd2,
    RING_PHYS = 2'd3
  } ring_e;

  typedef struct packed {
    logic  unsupp;
    logic  hit;
    ring_e ring;
  } match_t;

  // undo big-endian byte order: lane 0 holds the most significant byte
  function automatic logic [WORD_W-1:0] be_to_host(input logic [WORD_W-1:0] w);
    logic [WORD_W-1:0] r;
    for (int b = 0; b < NBYTES; b++) begin
      r[(NBYTES-1-b)*8 +: 8] = w[b*8 +: 8];
    end
    return r;
  endfunction

endpackage

// File: rtl/tcm_ctx_unpack.sv
module tcm_ctx_unpack
  import tcm_pkg::*;
#(
  parameter int CAM_W = 23,
  parameter int LS_W  = 8
) (
  input  logic [WORD_W-1:0] word_be_i,
  output logic              valid_o,
  output logic [CAM_W-1:0]  cam_o,
  output logic [LS_W-1:0]   ls_o
);

  logic [WORD_W-1:0] host_w;

  assign host_w  = be_to_host(word_be_i);
  assign valid_o = host_w[VLD_BIT];
  assign cam_o   = host_w[CAM_W-1:0];
  assign ls_o    = host_w[LS_W-1:0];

  logic unused_mid_bits;
  assign unused_mid_bits = ^host_w[VLD_BIT-1:CAM_W];

endmodule

// File: rtl/tcm_hwcam.sv
module tcm_hwcam #(
  parameter int BLK_W = 4,
  parameter int IDX_W = 19,
  parameter int TID_W = 8
) (
  input  logic [BLK_W-1:0]       chip_blk_i,
  input  logic [TID_W-1:0]       thread_id_i,
  input  logic                   tid8_mode_i,
  output logic [BLK_W+IDX_W-1:0] hw_cam_o
);

  logic [IDX_W-1:0] hw_idx;

  // marker bit sits directly above the thread id field
  always_comb begin
    hw_idx = '0;
    if (tid8_mode_i) begin
      hw_idx[TID_W-1:0] = thread_id_i;
      hw_idx[TID_W]     = 1'b1;
    end else begin
      hw_idx[TID_W-2:0] = thread_id_i[TID_W-2:0];
      hw_idx[TID_W-1]   = 1'b1;
    end
  end

  assign hw_cam_o = {chip_blk_i, hw_idx};

endmodule

// File: rtl/tcm_arbiter.sv
module tcm_arbiter
  import tcm_pkg::*;
#(
  parameter int CAM_W = 23,
  parameter int LS_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fmt_i,
  input  logic              ignore_i,
  input  logic [CAM_W-1:0]  tgt_cam_i,
  input  logic [CAM_W-1:0]  hw_cam_i,
  input  logic [NRINGS-1:0] vld_i,
  input  logic [CAM_W-1:0]  pool_cam_i,
  input  logic [CAM_W-1:0]  os_cam_i,
  input  logic [LS_W-1:0]   user_ls_i,
  input  logic [LS_W-1:0]   req_ls_i,
  output match_t            res_o
);

  logic phys_ok, pool_ok, os_ok, user_ok;

  assign phys_ok = vld_i[RING_PHYS] && (hw_cam_i   == tgt_cam_i);
  assign pool_ok = vld_i[RING_POOL] && (pool_cam_i == tgt_cam_i);
  assign os_ok   = vld_i[RING_OS]   && (os_cam_i   == tgt_cam_i);
  assign user_ok = vld_i[RING_USER] && (user_ls_i  == req_ls_i);

  always_comb begin
    res_o = '0;
    if (!fmt_i) begin
      if (ignore_i) begin
        res_o.unsupp = 1'b1;
      end else if (phys_ok) begin
        res_o.hit  = 1'b1;
        res_o.ring = RING_PHYS;
      end else if (pool_ok) begin
        res_o.hit  = 1'b1;
        res_o.ring = RING_POOL;
      end else if (os_ok) begin
        res_o.hit  = 1'b1;
        res_o.ring = RING_OS;
      end
    end else if (os_ok && user_ok) begin
      res_o.hit  = 1'b1;
      res_o.ring = RING_USER;
    end
  end

  a_r4_unsupported: assert property (@(posedge clk) disable iff (!rst_n)
    (!fmt_i && ignore_i) |-> (res_o.unsupp && !res_o.hit));

  a_r5_phys_first: assert property (@(posedge clk) disable iff (!rst_n)
    (!fmt_i && !ignore_i && phys_ok) |-> (res_o.hit && res_o.ring == RING_PHYS));

  a_r6_ring_valid: assert property (@(posedge clk) disable iff (!rst_n)
    res_o.hit |-> vld_i[res_o.ring]);

  a_r7_user_path: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt_i && res_o.hit) |-> (res_o.ring == RING_USER && os_ok && user_ok));

  a_r8_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !res_o.hit |-> (res_o.ring == RING_USER && (res_o.unsupp == (!fmt_i && ignore_i))));

endmodule

// File: rtl/ctx_cam_match.sv
module ctx_cam_match
  import tcm_pkg::*;
#(
  parameter int BLK_W   = 4,
  parameter int IDX_W   = 19,
  parameter int TID_W   = 8,
  parameter int LS_W    = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fmt_i,
  input  logic              ignore_i,
  input  logic [BLK_W-1:0]  tgt_blk_i,
  input  logic [IDX_W-1:0]  tgt_idx_i,
  input  logic [LS_W-1:0]   lsrv_i,
  input  logic [31:0]       phys_word_i,
  input  logic [31:0]       pool_word_i,
  input  logic [31:0]       os_word_i,
  input  logic [31:0]       user_word_i,
  input  logic [BLK_W-1:0]  chip_blk_i,
  input  logic [TID_W-1:0]  thread_id_i,
  input  logic              tid8_mode_i,
  output logic              hit_o,
  output logic [1:0]        ring_o,
  output logic              unsupp_o
);

  localparam int CAM_W = BLK_W + IDX_W;

  logic [NRINGS-1:0][WORD_W-1:0] words_be;
  logic [NRINGS-1:0]             vld;
  logic [NRINGS-1:0][CAM_W-1:0]  cam_a;
  logic [NRINGS-1:0][LS_W-1:0]   ls_a;
  logic [CAM_W-1:0]              tgt_cam;
  logic [CAM_W-1:0]              hw_cam;
  match_t                        res_c;
  match_t                        res_out;

  assign words_be = {phys_word_i, pool_word_i, os_word_i, user_word_i};
  assign tgt_cam  = {tgt_blk_i, tgt_idx_i};

  for (genvar g = 0; g < NRINGS; g++) begin : g_ring
    tcm_ctx_unpack #(.CAM_W(CAM_W), .LS_W(LS_W)) u_unpack (
      .word_be_i (words_be[g]),
      .valid_o   (vld[g]),
      .cam_o     (cam_a[g]),
      .ls_o      (ls_a[g])
    );
  end

  logic unused_fields;
  assign unused_fields = ^{cam_a[RING_PHYS], cam_a[RING_USER],
                           ls_a[RING_PHYS], ls_a[RING_POOL], ls_a[RING_OS]};

  tcm_hwcam #(.BLK_W(BLK_W), .IDX_W(IDX_W), .TID_W(TID_W)) u_hwcam (
    .chip_blk_i  (chip_blk_i),
    .thread_id_i (thread_id_i),
    .tid8_mode_i (tid8_mode_i),
    .hw_cam_o    (hw_cam)
  );

  tcm_arbiter #(.CAM_W(CAM_W), .LS_W(LS_W)) u_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .fmt_i      (fmt_i),
    .ignore_i   (ignore_i),
    .tgt_cam_i  (tgt_cam),
    .hw_cam_i   (hw_cam),
    .vld_i      (vld),
    .pool_cam_i (cam_a[RING_POOL]),
    .os_cam_i   (cam_a[RING_OS]),
    .user_ls_i  (ls_a[RING_USER]),
    .req_ls_i   (lsrv_i),
    .res_o      (res_c)
  );

  if (REG_OUT) begin : g_reg
    match_t res_q;
    logic   live_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        res_q  <= '0;
        live_q <= 1'b0;
      end else begin
        res_q  <= res_c;
        live_q <= 1'b1;
      end
    end

    assign res_out = res_q;

    a_r9_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      live_q |-> ({hit_o, ring_o, unsupp_o} ==
                  $past({res_c.hit, res_c.ring, res_c.unsupp})));
  end else begin : g_comb
    assign res_out = res_c;
  end

  assign hit_o    = res_out.hit;
  assign ring_o   = res_out.ring;
  assign unsupp_o = res_out.unsupp;

endmodule

// File: tb/ctx_cam_match_tb_top.sv
`timescale 1ns/1ps
module ctx_cam_match_tb_top;

  localparam int BLK_W = 4;
  localparam int IDX_W = 19;
  localparam int TID_W = 8;
  localparam int LS_W  = 8;
  localparam int CAM_W = BLK_W + IDX_W;

  logic clk = 1'b0;
  always #4 clk = ~clk;
  logic rst_n;

  logic             fmt, ign, t8;
  logic [BLK_W-1:0] tblk, chip;
  logic [IDX_W-1:0] tidx;
  logic [LS_W-1:0]  ls;
  logic [TID_W-1:0] tid;
  logic [31:0]      w_phys, w_pool, w_os, w_user;

  function automatic logic [31:0] swap32(input logic [31:0] x);
    return {x[7:0], x[15:8], x[23:16], x[31:24]};
  endfunction

  logic [31:0] b_phys, b_pool, b_os, b_user;
  assign b_phys = swap32(w_phys);
  assign b_pool = swap32(w_pool);
  assign b_os   = swap32(w_os);
  assign b_user = swap32(w_user);

  logic       hit_r, uns_r, hit_c, uns_c;
  logic [1:0] ring_r, ring_c;

  ctx_cam_match #(.BLK_W(BLK_W), .IDX_W(IDX_W), .TID_W(TID_W), .LS_W(LS_W), .REG_OUT(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .fmt_i(fmt), .ignore_i(ign), .tgt_blk_i(tblk), .tgt_idx_i(tidx),
    .lsrv_i(ls), .phys_word_i(b_phys), .pool_word_i(b_pool), .os_word_i(b_os), .user_word_i(b_user),
    .chip_blk_i(chip), .thread_id_i(tid), .tid8_mode_i(t8),
    .hit_o(hit_r), .ring_o(ring_r), .unsupp_o(uns_r));

  ctx_cam_match #(.BLK_W(BLK_W), .IDX_W(IDX_W), .TID_W(TID_W), .LS_W(LS_W), .REG_OUT(1'b0)) dut_c (
    .clk(clk), .rst_n(rst_n), .fmt_i(fmt), .ignore_i(ign), .tgt_blk_i(tblk), .tgt_idx_i(tidx),
    .lsrv_i(ls), .phys_word_i(b_phys), .pool_word_i(b_pool), .os_word_i(b_os), .user_word_i(b_user),
    .chip_blk_i(chip), .thread_id_i(tid), .tid8_mode_i(t8),
    .hit_o(hit_c), .ring_o(ring_c), .unsupp_o(uns_c));

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  function automatic logic [IDX_W-1:0] hw_index();
    if (t8) return IDX_W'(9'h100 | {1'b0, tid});
    return IDX_W'({1'b1, tid[6:0]});
  endfunction

  // expected {unsupp, hit, ring}
  function automatic logic [3:0] model();
    logic [CAM_W-1:0] tc = {tblk, tidx};
    logic [CAM_W-1:0] hw = {chip, hw_index()};
    if (!fmt) begin
      if (ign) return 4'b1000;
      if (w_phys[31] && hw == tc) return 4'b0111;
      if (w_pool[31] && w_pool[CAM_W-1:0] == tc) return 4'b0110;
      if (w_os[31] && w_os[CAM_W-1:0] == tc) return 4'b0101;
      return 4'b0000;
    end
    if (w_os[31] && w_os[CAM_W-1:0] == tc && w_user[31] && w_user[LS_W-1:0] == ls)
      return 4'b0100;
    return 4'b0000;
  endfunction

  task automatic cmp(input string req, input logic [3:0] got, input logic [3:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got {unsupp,hit,ring}=%b expected %b", req, got, exp);
    end
  endtask

  // called just after a falling edge with inputs set
  task automatic run(input string req);
    logic [3:0] e;
    e = model();
    #2;
    cmp({req, " comb"}, {uns_c, hit_c, ring_c}, e);
    @(negedge clk);
    cmp({req, " R9 reg"}, {uns_r, hit_r, ring_r}, e);
  endtask

  task automatic clear_all();
    fmt = 0; ign = 0; t8 = 0; tblk = 4'h3; tidx = 19'h1234; ls = 8'h5a;
    chip = 4'h9; tid = 8'h11;
    w_phys = 0; w_pool = 0; w_os = 0; w_user = 0;
  endtask

  function automatic logic [31:0] rnd_word(input logic [CAM_W-1:0] tc);
    logic [31:0] w = $urandom;
    w[31] = ($urandom % 4) != 0;
    if ($urandom % 2) w[CAM_W-1:0] = tc;
    return w;
  endfunction

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    clear_all();
    rst_n = 0;
    w_os = {1'b1, 8'h00, tblk, tidx};   // would match OS if not in reset
    repeat (3) @(negedge clk);
    cmp("R9 reset", {uns_r, hit_r, ring_r}, 4'b0000);
    rst_n = 1;
    @(negedge clk);

    // R4: ignore bit with format 0, every ring matching
    clear_all(); ign = 1; chip = tblk; tidx = hw_index();
    w_phys = 32'h8000_0000; w_pool = {9'h100, tblk, tidx}; w_os = w_pool;
    run("R4");
    // R5: all three match -> physical
    ign = 0; run("R5 all");
    // R5: physical invalid -> pool
    w_phys = 0; run("R5 pool");
    // R6: only OS valid
    w_pool[31] = 0; run("R6 os");
    // R6/R8: pool cam matches but invalid, OS cam off by one
    w_os[0] = ~w_os[0]; run("R8 none");
    // R1: block field differs
    clear_all(); w_os = {1'b1, 8'h00, tblk ^ 4'h1, tidx}; run("R1 blk");
    // R2: word presented in the wrong byte order
    w_os = swap32({1'b1, 8'h00, tblk, tidx}); run("R2 order");
    w_os = {1'b1, 8'h00, tblk, tidx}; run("R2 good");

    // R3: thread id with bit 7 set in both widths
    clear_all(); tid = 8'h85; chip = tblk; w_phys = 32'h8000_0000;
    t8 = 0; tidx = 19'h00085; run("R3 7bit");
    t8 = 1; run("R3 8bit miss");
    tidx = 19'h00185; run("R3 8bit hit");
    t8 = 0; run("R3 7bit miss");

    // R7: user path
    clear_all(); fmt = 1; ign = 1;
    w_os = {1'b1, 8'h00, tblk, tidx}; w_user = {24'h80_0000, ls};
    run("R7 user");
    w_user[0] = ~w_user[0]; run("R7 ls miss");
    w_user[0] = ~w_user[0]; w_os[31] = 0; run("R7 os invalid");
    w_os[31] = 1; w_user[31] = 0; run("R7 user invalid");
    clear_all(); fmt = 1; chip = tblk; tidx = hw_index(); w_phys = 32'h8000_0000;
    w_pool = {9'h100, tblk, tidx}; run("R7 no fmt0 rings");

    for (int i = 0; i < 600; i++) begin
      logic [CAM_W-1:0] tc;
      fmt  = 1'($urandom); ign = ($urandom % 4) == 0; t8 = 1'($urandom);
      tblk = BLK_W'($urandom); tidx = IDX_W'($urandom); chip = BLK_W'($urandom);
      tid  = TID_W'($urandom); ls = LS_W'($urandom);
      if ($urandom % 2) begin chip = tblk; tidx = hw_index(); end
      tc = {tblk, tidx};
      w_phys = rnd_word(tc); w_pool = rnd_word(tc); w_os = rnd_word(tc);
      w_user = $urandom; w_user[31] = ($urandom % 4) != 0;
      if ($urandom % 2) w_user[LS_W-1:0] = ls;
      run(fmt ? "R7 random" : "R5 random");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule